// File: doc/BRIEF.md
# PCIe Transceiver Reset Sequencer

This block drives the four reset controls of a serial transceiver channel carrying PCI Express traffic, or of a bonded group of up to four lanes. After a power-on start it holds the PLL in reset for a fixed interval. It then releases the transmit digital reset once the PLL reports lock. Next it waits out the reconfiguration busy flag, and finally it releases the receive analog and receive digital resets on the same edge. That last release ends the initialization/compliance phase.

From then on the block runs the normal phase. Whenever the receiver frequency lock of any lane drops, the block waits until every lane is locked again. It then waits a programmable settle time and pulses the receive digital reset for two cycles, so that the receive phase-compensation FIFO starts cleanly. If PLL lock is lost at any time after it was first seen, the whole sequence starts again from the PLL hold.

All control pins are plain levels; the block has no data path and no valid/ready handshake. The lock, busy, start and frequency-lock inputs are resynchronized through two flops. Every reset output comes straight from a flop.

Top module: `pcie_rst_seq`

## Requirements
- R1: While `rst_n` is low, `pll_rst_o`, `tx_dig_rst_o`, `rx_ana_rst_o` and `rx_dig_rst_o` are 1 and `normal_phase_o` is 0. Asserting `rst_n` forces these values at once, without waiting for a clock edge.
- R2: With `start_i` low, nothing is released. Once `start_i` is first sampled high, `pll_rst_o` falls on the (HOLD_CYCLES+3)-th rising edge, counted from that first sampling edge as edge 1. The other three resets stay 1 throughout.
- R3: After `pll_rst_o` is low, `tx_dig_rst_o` stays 1 until `pll_locked_i` is sampled high. It falls on the 3rd rising edge counted from that sampling edge.
- R4: With `tx_dig_rst_o` low, `rx_ana_rst_o` stays 1 while `reconf_busy_i` is high. Once busy is sampled low, `rx_ana_rst_o` falls on the 5th rising edge. This is two full cycles after the synchronized busy-low has been acted on.
- R5: In the compliance phase, `rx_dig_rst_o` falls on the same edge as `rx_ana_rst_o`, whatever the values on `rx_flock_i`.
- R6: `normal_phase_o` rises on the edge where the receive resets are released in R5. It stays 1 until the next PLL lock loss or `rst_n`.
- R7: In the normal phase, while any bit of `rx_flock_i` is 0, `rx_dig_rst_o` stays 0 and no FIFO reset pulse starts. If all bits are already 1 on entry to the normal phase, no pulse occurs.
- R8: Count from the edge that first samples all LANES bits of `rx_flock_i` high. `rx_dig_rst_o` rises on the (SETTLE_CYCLES+3)-th edge and stays 1 for exactly two cycles.
- R9: If any lane drops during the settle wait, the wait restarts. The pulse timing of R8 is then counted from the edge where all lanes are high again.
- R10: Once `tx_dig_rst_o` has been released, if `pll_locked_i` is sampled low, then on the 3rd edge all four resets are 1 and `normal_phase_o` is 0. `pll_rst_o` then falls HOLD_CYCLES edges later, and the sequence resumes at R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | Power-on start level |
| pll_locked_i | input | 1 | PLL lock flag |
| reconf_busy_i | input | 1 | Reconfiguration busy flag |
| rx_flock_i | input | LANES | Receiver frequency-lock flag per lane |
| pll_rst_o | output | 1 | PLL reset, active high |
| tx_dig_rst_o | output | 1 | Transmit digital reset, active high |
| rx_ana_rst_o | output | 1 | Receive analog reset, active high |
| rx_dig_rst_o | output | 1 | Receive digital reset, active high |
| normal_phase_o | output | 1 | High once the normal phase is entered |

## Verification
The bound checker watches the ordering of the reset outputs on every cycle. It confirms that a held PLL reset keeps every other reset held, that the receive resets are never released ahead of the transmit reset, and that the compliance release of the two receive resets is simultaneous. It also confirms that a normal-phase FIFO pulse lasts two cycles and that the status flag never claims the normal phase while the receive path is held. Exact latencies cannot be seen from one cycle alone, so the bench's scenarios show them. These include the PLL hold length, the busy-to-release gap and the settle delay, measured from each input change. The bench also shows that frequency lock is ignored during compliance, that each single lane drop leads to a pulse, that the settle wait restarts, and that the PLL re-hold follows a lock loss.

// File: rtl/prst_pkg.sv
package prst_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PLL_HOLD,
    ST_WAIT_PLL,
    ST_WAIT_BUSY,
    ST_BUSY_GAP,
    ST_RUN,
    ST_WAIT_FLOCK,
    ST_SETTLE,
    ST_FIFO_RST
  } seq_state_e;

  typedef struct packed {
    logic pll;
    logic txd;
    logic rxa;
    logic rxd;
    logic normal;
  } rst_vec_t;

  localparam rst_vec_t RST_ALL = '{pll: 1'b1, txd: 1'b1, rxa: 1'b1, rxd: 1'b1, normal: 1'b0};

  function automatic rst_vec_t decode_outputs(seq_state_e st);
    rst_vec_t v;
    case (st)
      ST_IDLE, ST_PLL_HOLD:
        v = RST_ALL;
      ST_WAIT_PLL:
        v = '{pll: 1'b0, txd: 1'b1, rxa: 1'b1, rxd: 1'b1, normal: 1'b0};
      ST_WAIT_BUSY, ST_BUSY_GAP:
        v = '{pll: 1'b0, txd: 1'b0, rxa: 1'b1, rxd: 1'b1, normal: 1'b0};
      ST_RUN, ST_WAIT_FLOCK, ST_SETTLE:
        v = '{pll: 1'b0, txd: 1'b0, rxa: 1'b0, rxd: 1'b0, normal: 1'b1};
      ST_FIFO_RST:
        v = '{pll: 1'b0, txd: 1'b0, rxa: 1'b0, rxd: 1'b1, normal: 1'b1};
      default:
        v = RST_ALL;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/prst_sync.sv
module prst_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/prst_timer.sv
module prst_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/prst_fsm.sv
module prst_fsm
  import prst_pkg::*;
#(
  parameter int TW            = 8,
  parameter int HOLD_CYCLES   = 125,
  parameter int SETTLE_CYCLES = 64,
  parameter int GAP_CYCLES    = 2,
  parameter int PULSE_CYCLES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_s,
  input  logic          lock_s,
  input  logic          busy_s,
  input  logic          all_lk_s,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output rst_vec_t      outs_o
);
  localparam logic [TW-1:0] HOLD_LD   = TW'(HOLD_CYCLES - 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYCLES - 1);
  localparam logic [TW-1:0] GAP_LD    = TW'(GAP_CYCLES - 1);
  localparam logic [TW-1:0] PULSE_LD  = TW'(PULSE_CYCLES - 1);

  seq_state_e state_q, state_n;
  rst_vec_t   outs_q;
  logic       lock_tracked;

  // lock is only expected to be high once the PLL wait is over
  assign lock_tracked = !(state_q inside {ST_IDLE, ST_PLL_HOLD, ST_WAIT_PLL});

  always_comb begin
    state_n  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (start_s) begin
        state_n  = ST_PLL_HOLD;
        tmr_load = 1'b1;
        tmr_val  = HOLD_LD;
      end
      ST_PLL_HOLD: if (tmr_done) state_n = ST_WAIT_PLL;
      ST_WAIT_PLL: if (lock_s) state_n = ST_WAIT_BUSY;
      ST_WAIT_BUSY: if (!busy_s) begin
        state_n  = ST_BUSY_GAP;
        tmr_load = 1'b1;
        tmr_val  = GAP_LD;
      end
      ST_BUSY_GAP: if (tmr_done) state_n = ST_RUN;
      ST_RUN: if (!all_lk_s) state_n = ST_WAIT_FLOCK;
      ST_WAIT_FLOCK: if (all_lk_s) begin
        state_n  = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = SETTLE_LD;
      end
      ST_SETTLE: begin
        if (!all_lk_s) begin
          state_n = ST_WAIT_FLOCK;
        end else if (tmr_done) begin
          state_n  = ST_FIFO_RST;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LD;
        end
      end
      ST_FIFO_RST: if (tmr_done) state_n = ST_RUN;
      default: state_n = ST_IDLE;
    endcase

    if (lock_tracked && !lock_s) begin
      state_n  = ST_PLL_HOLD;
      tmr_load = 1'b1;
      tmr_val  = HOLD_LD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      outs_q  <= RST_ALL;
    end else begin
      state_q <= state_n;
      outs_q  <= decode_outputs(state_n);
    end
  end

  assign outs_o = outs_q;
endmodule

// File: rtl/pcie_rst_seq.sv
module pcie_rst_seq
  import prst_pkg::*;
#(
  parameter int LANES         = 4,
  parameter int HOLD_CYCLES   = 125,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pll_locked_i,
  input  logic             reconf_busy_i,
  input  logic [LANES-1:0] rx_flock_i,
  output logic             pll_rst_o,
  output logic             tx_dig_rst_o,
  output logic             rx_ana_rst_o,
  output logic             rx_dig_rst_o,
  output logic             normal_phase_o
);
  localparam int GAP_CYCLES   = 2;
  localparam int PULSE_CYCLES = 2;
  localparam int MAX_A        = (HOLD_CYCLES > SETTLE_CYCLES) ? HOLD_CYCLES : SETTLE_CYCLES;
  localparam int MAX_CNT      = (MAX_A > PULSE_CYCLES) ? MAX_A : PULSE_CYCLES;
  localparam int TW           = $clog2(MAX_CNT + 1);
  localparam int SW           = LANES + 3;

  logic [SW-1:0] raw_in, syn;
  logic          start_s, lock_s, busy_s, all_lk_s;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  rst_vec_t      outs;

  assign raw_in = {start_i, pll_locked_i, reconf_busy_i, rx_flock_i};

  prst_sync #(.W(SW)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw_in),
    .sync_o (syn)
  );

  assign start_s  = syn[SW-1];
  assign lock_s   = syn[SW-2];
  assign busy_s   = syn[SW-3];
  assign all_lk_s = &syn[LANES-1:0];

  prst_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .done_o    (tmr_done)
  );

  prst_fsm #(
    .TW           (TW),
    .HOLD_CYCLES  (HOLD_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .GAP_CYCLES   (GAP_CYCLES),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_s (start_s),
    .lock_s  (lock_s),
    .busy_s  (busy_s),
    .all_lk_s(all_lk_s),
    .tmr_done(tmr_done),
    .tmr_load(tmr_load),
    .tmr_val (tmr_val),
    .outs_o  (outs)
  );

  assign pll_rst_o      = outs.pll;
  assign tx_dig_rst_o   = outs.txd;
  assign rx_ana_rst_o   = outs.rxa;
  assign rx_dig_rst_o   = outs.rxd;
  assign normal_phase_o = outs.normal;
endmodule

// File: rtl/pcie_rst_seq_chk.sv
module pcie_rst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pll_rst_o,
  input logic tx_dig_rst_o,
  input logic rx_ana_rst_o,
  input logic rx_dig_rst_o,
  input logic normal_phase_o
);
  a_r2_pll_hold_keeps_all: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst_o |-> (tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o));

  a_r3_tx_after_pll: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_dig_rst_o |-> !pll_rst_o);

  a_r4_rx_after_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ana_rst_o |-> !tx_dig_rst_o);

  a_r5_rx_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ana_rst_o) |-> $fell(rx_dig_rst_o));

  a_r6_normal_means_rx_free: assert property (@(posedge clk) disable iff (!rst_n)
    normal_phase_o |-> !rx_ana_rst_o);

  a_r8_two_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_dig_rst_o) && !rx_ana_rst_o) |=> (rx_dig_rst_o ##1 (!rx_dig_rst_o || pll_rst_o)));
endmodule

bind pcie_rst_seq pcie_rst_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pll_rst_o     (pll_rst_o),
  .tx_dig_rst_o  (tx_dig_rst_o),
  .rx_ana_rst_o  (rx_ana_rst_o),
  .rx_dig_rst_o  (rx_dig_rst_o),
  .normal_phase_o(normal_phase_o)
);

// File: tb/test_pcie_rst_seq.sv
module test_pcie_rst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int HOLD       = 16;
  localparam int SETTLE     = 10;

  logic clk = 1'b0;
  logic rst_n, start_i, pll_locked_i, reconf_busy_i;
  logic [LANES-1:0] rx_flock_i;
  logic pll_rst_o, tx_dig_rst_o, rx_ana_rst_o, rx_dig_rst_o, normal_phase_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcie_rst_seq #(.LANES(LANES), .HOLD_CYCLES(HOLD), .SETTLE_CYCLES(SETTLE)) i_pcie_rst_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pll_locked_i(pll_locked_i),
    .reconf_busy_i(reconf_busy_i), .rx_flock_i(rx_flock_i),
    .pll_rst_o(pll_rst_o), .tx_dig_rst_o(tx_dig_rst_o), .rx_ana_rst_o(rx_ana_rst_o),
    .rx_dig_rst_o(rx_dig_rst_o), .normal_phase_o(normal_phase_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic sig(input int idx);
    case (idx)
      0: return pll_rst_o;
      1: return tx_dig_rst_o;
      2: return rx_ana_rst_o;
      3: return rx_dig_rst_o;
      default: return normal_phase_o;
    endcase
  endfunction

  // counts rising edges until signal idx reads val; -1 if never within limit
  task automatic measure(input int idx, input logic val, input int limit, output int n);
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (sig(idx) == val) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check_pulse(input string req, input int exp_lat);
    int n;
    measure(3, 1'b1, exp_lat + 20, n);
    chk({req, " pulse latency"}, n, exp_lat);
    @(negedge clk);
    chk({req, " pulse 2nd cycle"}, rx_dig_rst_o, 1);
    @(negedge clk);
    chk({req, " pulse ended"}, rx_dig_rst_o, 0);
  endtask

  initial begin
    int n;
    logic [LANES-1:0] pat [4];
    pat[0] = 4'b1111; pat[1] = 4'b0000; pat[2] = 4'b0101; pat[3] = 4'b1110;

    rst_n = 1'b0; start_i = 1'b0; pll_locked_i = 1'b0; reconf_busy_i = 1'b1; rx_flock_i = '0;
    idle(3);
    // R1 reset values
    chk("R1 pll", pll_rst_o, 1); chk("R1 tx", tx_dig_rst_o, 1);
    chk("R1 rxa", rx_ana_rst_o, 1); chk("R1 rxd", rx_dig_rst_o, 1);
    chk("R1 normal", normal_phase_o, 0);
    rst_n = 1'b1;
    idle(6);
    chk("R2 no start keeps pll reset", pll_rst_o, 1);

    for (int r = 0; r < 4; r++) begin
      rx_flock_i = pat[r];
      if (r == 0) begin
        start_i = 1'b1;
        measure(0, 1'b0, HOLD + 20, n);
        chk("R2 pll hold latency", n, HOLD + 3);
        chk("R2 tx still held", tx_dig_rst_o, 1);
        chk("R2 rxa still held", rx_ana_rst_o, 1);
      end
      idle(2);
      chk("R3 tx waits for lock", tx_dig_rst_o, 1);
      pll_locked_i = 1'b1;
      measure(1, 1'b0, 20, n);
      chk("R3 tx release latency", n, 3);
      chk("R3 rxa held at tx release", rx_ana_rst_o, 1);
      idle(r);
      chk("R4 rxa waits for busy", rx_ana_rst_o, 1);
      reconf_busy_i = 1'b0;
      measure(2, 1'b0, 20, n);
      chk("R4 rxa release latency", n, 5);
      chk("R5 rxd released with rxa", rx_dig_rst_o, 0);
      chk("R6 normal phase entered", normal_phase_o, 1);

      if (pat[r] == '1) begin
        idle(SETTLE + 6);
        chk("R7 no pulse when locked on entry", rx_dig_rst_o, 0);
      end else begin
        idle(SETTLE + 6);
        chk("R7 no pulse while a lane unlocked", rx_dig_rst_o, 0);
        rx_flock_i = '1;
        check_pulse("R8 entry relock", SETTLE + 3);
      end

      // each single lane drop
      for (int l = 0; l < LANES; l++) begin
        rx_flock_i[l] = 1'b0;
        idle(SETTLE + 4);
        chk("R7 lane drop holds off pulse", rx_dig_rst_o, 0);
        rx_flock_i[l] = 1'b1;
        check_pulse("R8 lane relock", SETTLE + 3);
      end

      // R9: all lanes needed, and a drop during settle restarts it
      rx_flock_i = 4'b0110;
      idle(4);
      rx_flock_i[0] = 1'b1;
      idle(SETTLE + 6);
      chk("R9 bonded waits for last lane", rx_dig_rst_o, 0);
      rx_flock_i[3] = 1'b1;
      idle(r + 2);
      rx_flock_i[(r + 1) % LANES] = 1'b0;
      @(negedge clk);
      rx_flock_i[(r + 1) % LANES] = 1'b1;
      check_pulse("R9 settle restart", SETTLE + 3);

      // R10 lock loss from the normal phase
      pll_locked_i = 1'b0;
      measure(0, 1'b1, 20, n);
      chk("R10 pll reasserted latency", n, 3);
      chk("R10 tx reasserted", tx_dig_rst_o, 1);
      chk("R10 rxa reasserted", rx_ana_rst_o, 1);
      chk("R10 rxd reasserted", rx_dig_rst_o, 1);
      chk("R10 normal cleared", normal_phase_o, 0);
      reconf_busy_i = 1'b1;
      measure(0, 1'b0, HOLD + 20, n);
      chk("R10 re-hold length", n, HOLD);
    end

    // R1 asynchronous assertion
    rst_n = 1'b0;
    #1;
    chk("R1 async pll", pll_rst_o, 1);
    chk("R1 async tx", tx_dig_rst_o, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule